// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is a small coprocessor attached beside a processor core. It holds eight 32-bit registers. The core reaches them only through two register-transfer commands: one moves a word into a register and the other moves a register out to the core. Each command carries an instruction word, and the register index comes from one field of that word. A separate debug port reads and writes the same registers by direct index. Every other command kind addressed to this coprocessor gets a "cannot handle" response, which the core treats as an undefined-instruction trap.

Register 0 is an identification register. It always reads back a fixed constant. Register 1 holds the processor configuration. Four of its bits drive live configuration outputs that select program address width, data address width, abort timing and byte order. At reset these bits are loaded from four strap inputs. A later write to register 1 updates the outputs and raises a one-cycle notify pulse, so the core re-samples its mode. Registers 2 to 7 are plain storage.

Top module: `sysctl_cop`

## Requirements
- R1: A command's register index is taken from instruction bits 19:16, keeping only the low 3 bits. Indices 8 to 15 therefore alias onto 0 to 7. All other instruction bits are ignored.
- R2: A read of register 0 returns 0x41440110 on both the command path and the debug path, whatever was last written to it.
- R3: Reset is synchronous and active-high. It loads register 1 bits 7:4 from `strap_cfg[3:0]`: bit 4 from strap 0 (32-bit program space), bit 5 from strap 1 (32-bit data space), bit 6 from strap 2 (late abort), bit 7 from strap 3 (big-endian). All other bits of register 1 and all of registers 2 to 7 reset to zero. `cfg_out` then equals the straps, and later strap changes have no effect until the next reset.
- R4: A write to register 1 from either path sets `cfg_out` to the written bits 7:4 in the cycle after the write edge. In that same cycle only, `cfg_notify` is 1. A write to any other index leaves `cfg_notify` at 0.
- R5: Registers 2 to 7, and bits 31:8 and 3:0 of register 1, read back exactly as last written.
- R6: `cmd_kind` 0 means move-to-coprocessor (write `cmd_wdata`) and 1 means move-from-coprocessor (read). For both, `rsp_valid` is 1 with `rsp_code` 2'b01 (done) in the cycle after `cmd_valid`. `rsp_rdata` carries the register value for a read and is 0 for every other response. When `cmd_valid` is 0, `rsp_valid` is 0 in the next cycle.
- R7: `cmd_kind` values 2 to 7 (memory load, memory store, data processing, reserved) get `rsp_code` 2'b10 (cannot handle). They change no register and raise no notify pulse.
- R8: A debug write to an index of 8 or more is ignored. A debug read of such an index leaves `dbg_rdata` unchanged. A debug read of indices 0 to 7 loads `dbg_rdata` in the cycle after the request.
- R9: When a command write and a debug write hit the same register in the same cycle, the command data is stored. When they hit different registers, both are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_cfg | input | 4 | Configuration straps sampled during reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 3 | Command kind (0 move-to, 1 move-from, 2..7 rejected) |
| cmd_instr | input | 32 | Instruction word; register index in bits 19:16 |
| cmd_wdata | input | 32 | Data for move-to |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 01 done, 10 cannot handle |
| rsp_rdata | output | 32 | Move-from data |
| dbg_wr | input | 1 | Debug write strobe |
| dbg_rd | input | 1 | Debug read strobe |
| dbg_idx | input | 4 | Debug register index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, held between reads |
| cfg_out | output | 4 | Live configuration bits (register 1 bits 7:4) |
| cfg_notify | output | 1 | One-cycle pulse after a register 1 write |

## Verification
The bench first resets the block once for each of the 16 strap values, which shows that every configuration bit lands in its own position. It then writes all 16 command indices with index-unique data and reads every register back on both paths. This separates correct aliasing from a wrong index field and shows that the identification constant overrides stored data. A second sweep covers all 16 debug indices, which tells real writes apart from out-of-range ones that must be ignored. Every rejected command kind is issued against every index, and simultaneous writes to the same register and to different registers show the port priority.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [2:0] {
    KIND_MOVE_TO   = 3'd0,
    KIND_MOVE_FROM = 3'd1,
    KIND_MEM_LOAD  = 3'd2,
    KIND_MEM_STORE = 3'd3,
    KIND_DATA_PROC = 3'd4
  } cmd_kind_e;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_DONE = 2'b01,
    RSP_CANT = 2'b10
  } rsp_code_e;

  localparam logic [31:0] SYSCTL_ID = 32'h4144_0110;
endpackage

// File: rtl/sysctl_cmd_dec.sv
module sysctl_cmd_dec
  import sysctl_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IW      = 32,
  parameter int IDX_LSB = 16,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_kind,
  input  logic [IW-1:0] cmd_instr,
  output logic          wr_en,
  output logic [AW-1:0] reg_idx,
  input  logic [DW-1:0] rd_data,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  output logic [DW-1:0] rsp_rdata
);
  logic is_to, is_from, accepted;

  always_comb begin
    is_to    = (cmd_kind == KIND_MOVE_TO);
    is_from  = (cmd_kind == KIND_MOVE_FROM);
    accepted = is_to | is_from;
    reg_idx  = cmd_instr[IDX_LSB +: AW];
    wr_en    = cmd_valid & is_to;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_NONE;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_code  <= !cmd_valid ? RSP_NONE : (accepted ? RSP_DONE : RSP_CANT);
      rsp_rdata <= (cmd_valid & is_from) ? rd_data : '0;
    end
  end

  p_one_rsp_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid);
  p_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind > 3'd1) |=> (rsp_code == RSP_CANT && rsp_rdata == '0));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int          NREGS   = 8,
  parameter int          DW      = 32,
  parameter int          CFG_LSB = 4,
  parameter int          NCFG    = 4,
  parameter logic [31:0] ID_VAL  = 32'h4144_0110,
  localparam int         AW      = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCFG-1:0] strap,
  input  logic            wa_en,
  input  logic [AW-1:0]   wa_idx,
  input  logic [DW-1:0]   wa_data,
  input  logic            wb_en,
  input  logic [AW-1:0]   wb_idx,
  input  logic [DW-1:0]   wb_data,
  input  logic [AW-1:0]   ra_idx,
  output logic [DW-1:0]   ra_data,
  input  logic [AW-1:0]   rb_idx,
  output logic [DW-1:0]   rb_data,
  output logic [NCFG-1:0] cfg_bits
);
  logic [DW-1:0] mem [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    logic [DW-1:0] rst_val;
    if (g == 1) begin : g_cfg
      always_comb begin
        rst_val = '0;
        rst_val[CFG_LSB +: NCFG] = strap;
      end
    end else begin : g_plain
      assign rst_val = '0;
    end

    always_ff @(posedge clk) begin
      if (rst)                                 mem[g] <= rst_val;
      else if (wa_en && wa_idx == AW'(g))      mem[g] <= wa_data;
      else if (wb_en && wb_idx == AW'(g))      mem[g] <= wb_data;
    end
  end

  always_comb begin
    ra_data  = (ra_idx == '0) ? ID_VAL[DW-1:0] : mem[ra_idx];
    rb_data  = (rb_idx == '0) ? ID_VAL[DW-1:0] : mem[rb_idx];
    cfg_bits = mem[1][CFG_LSB +: NCFG];
  end

  p_cmd_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wb_en && wa_idx == wb_idx) |=> (mem[$past(wa_idx)] == $past(wa_data)));
endmodule

// File: rtl/sysctl_cfg_ctrl.sv
module sysctl_cfg_ctrl #(
  parameter int NCFG = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_hit,
  input  logic [NCFG-1:0] cfg_bits,
  output logic [NCFG-1:0] cfg_out,
  output logic            cfg_notify
);
  always_ff @(posedge clk) begin
    if (rst) cfg_notify <= 1'b0;
    else     cfg_notify <= wr_hit;
  end

  assign cfg_out = cfg_bits;

  p_notify_cause_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_notify |-> $past(wr_hit));
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_notify && !$past(rst)) |-> $stable(cfg_out));
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter int NREGS   = 8,
  parameter int DW      = 32,
  parameter int IW      = 32,
  parameter int IDX_LSB = 16,
  parameter int IDXW    = 4,
  parameter int CFG_LSB = 4,
  parameter int NCFG    = 4,
  localparam int AW     = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCFG-1:0] strap_cfg,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_kind,
  input  logic [IW-1:0]   cmd_instr,
  input  logic [DW-1:0]   cmd_wdata,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code,
  output logic [DW-1:0]   rsp_rdata,
  input  logic            dbg_wr,
  input  logic            dbg_rd,
  input  logic [IDXW-1:0] dbg_idx,
  input  logic [DW-1:0]   dbg_wdata,
  output logic [DW-1:0]   dbg_rdata,
  output logic [NCFG-1:0] cfg_out,
  output logic            cfg_notify
);
  logic          cmd_we;
  logic [AW-1:0] cmd_idx;
  logic [DW-1:0] cmd_rd, dbg_rd_val;
  logic          dbg_ok, dbg_we;
  logic [AW-1:0] dbg_sidx;
  logic [NCFG-1:0] cfg_bits;
  logic          cfg_hit;

  always_comb begin
    dbg_ok   = (dbg_idx < IDXW'(NREGS));
    dbg_sidx = dbg_idx[AW-1:0];
    dbg_we   = dbg_wr & dbg_ok;
    cfg_hit  = (cmd_we && cmd_idx == AW'(1)) || (dbg_we && dbg_sidx == AW'(1));
  end

  sysctl_cmd_dec #(.DW(DW), .IW(IW), .IDX_LSB(IDX_LSB), .AW(AW)) u_dec (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_instr(cmd_instr), .wr_en(cmd_we), .reg_idx(cmd_idx), .rd_data(cmd_rd),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata)
  );

  sysctl_regfile #(.NREGS(NREGS), .DW(DW), .CFG_LSB(CFG_LSB), .NCFG(NCFG),
                   .ID_VAL(SYSCTL_ID)) u_rf (
    .clk(clk), .rst(rst), .strap(strap_cfg),
    .wa_en(cmd_we), .wa_idx(cmd_idx), .wa_data(cmd_wdata),
    .wb_en(dbg_we), .wb_idx(dbg_sidx), .wb_data(dbg_wdata),
    .ra_idx(cmd_idx), .ra_data(cmd_rd),
    .rb_idx(dbg_sidx), .rb_data(dbg_rd_val),
    .cfg_bits(cfg_bits)
  );

  sysctl_cfg_ctrl #(.NCFG(NCFG)) u_cfg (
    .clk(clk), .rst(rst), .wr_hit(cfg_hit), .cfg_bits(cfg_bits),
    .cfg_out(cfg_out), .cfg_notify(cfg_notify)
  );

  always_ff @(posedge clk) begin
    if (rst)                  dbg_rdata <= '0;
    else if (dbg_rd && dbg_ok) dbg_rdata <= dbg_rd_val;
  end

  p_id_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == KIND_MOVE_FROM && cmd_idx == '0) |=> rsp_rdata == SYSCTL_ID[DW-1:0]);
  p_id_dbg_r2: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd && dbg_idx == '0) |=> dbg_rdata == SYSCTL_ID[DW-1:0]);
  p_dbg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd && !dbg_ok) |=> $stable(dbg_rdata));
endmodule

// File: tb/tb_sysctl_cop.sv
module tb_sysctl_cop;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h4144_0110;

  logic        clk = 1'b0, rst = 1'b1;
  logic [3:0]  strap_cfg = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_kind = '0;
  logic [31:0] cmd_instr = '0, cmd_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_rdata;
  logic        dbg_wr = 1'b0, dbg_rd = 1'b0;
  logic [3:0]  dbg_idx = '0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic [3:0]  cfg_out;
  logic        cfg_notify;

  int vectors = 0, fails = 0;
  logic [31:0] model [8];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_cop dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expv(input int i);
    return (i == 0) ? ID : model[i];
  endfunction

  function automatic logic [31:0] instr_of(input logic [3:0] ix);
    return (32'hEE1F_0F1F & ~32'h000F_0000) | (32'(ix) << 16);
  endfunction

  function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
    return salt ^ (32'(i) * 32'h0103_0507) ^ 32'h5A00_00F0;
  endfunction

  task automatic do_reset(input logic [3:0] s);
    @(negedge clk);
    rst = 1'b1; strap_cfg = s;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    model[1][7:4] = s;
  endtask

  task automatic do_cmd(input logic [2:0] k, input logic [3:0] ix, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_instr = instr_of(ix); cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_dbg(input logic w, input logic r, input logic [3:0] ix, input logic [31:0] d);
    @(negedge clk);
    dbg_wr = w; dbg_rd = r; dbg_idx = ix; dbg_wdata = d;
    @(negedge clk);
    dbg_wr = 1'b0; dbg_rd = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 8; i++) begin
      do_cmd(3'd1, 4'(i + ((i % 2) * 8)), 32'hDEAD_BEEF);
      chk({req, " cmd read"}, rsp_rdata, expv(i));
      chk({req, " cmd code"}, {30'd0, rsp_code}, 32'd1);
      do_dbg(1'b0, 1'b1, 4'(i), '0);
      chk({req, " dbg read"}, dbg_rdata, expv(i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R3: reset with every strap value
    for (int s = 0; s < 16; s++) begin
      do_reset(4'(s));
      chk("R3 cfg_out after reset", {28'd0, cfg_out}, 32'(s));
      chk("R3 notify idle", {31'd0, cfg_notify}, 32'd0);
      chk("R6 rsp idle", {31'd0, rsp_valid}, 32'd0);
      strap_cfg = ~4'(s);
      do_dbg(1'b0, 1'b1, 4'd1, '0);
      chk("R3 reg1 reset", dbg_rdata, 32'(s) << 4);
      chk("R3 strap ignored after reset", {28'd0, cfg_out}, 32'(s));
      do_cmd(3'd1, 4'd5, '0);
      chk("R3 reg5 reset", rsp_rdata, 32'd0);
    end
    do_reset(4'b0110);
    read_all("R3");

    // R1 R4 R5 R6: command write sweep over all 16 index codes
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d = pat(i, 32'h1357_9BDF);
      do_cmd(3'd0, 4'(i), d);
      model[i % 8] = d;
      chk("R6 write done", {29'd0, rsp_valid, rsp_code}, 32'd5);
      chk("R6 write rdata zero", rsp_rdata, 32'd0);
      chk("R4 notify on write", {31'd0, cfg_notify}, 32'((i % 8) == 1));
      chk("R4 cfg_out follows", {28'd0, cfg_out}, 32'(model[1][7:4]));
      @(negedge clk);
      chk("R4 notify one cycle", {31'd0, cfg_notify}, 32'd0);
      read_all("R1 R2 R5");
    end

    // R8 R4: debug write sweep, indices 8..15 ignored
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d = pat(i, 32'hCAFE_0F0F);
      do_dbg(1'b1, 1'b0, 4'(i), d);
      if (i < 8) model[i] = d;
      chk("R4 R8 dbg notify", {31'd0, cfg_notify}, 32'(i == 1));
      chk("R4 cfg_out after dbg", {28'd0, cfg_out}, 32'(model[1][7:4]));
    end
    read_all("R8");

    // R8: debug read out of range holds
    do_dbg(1'b0, 1'b1, 4'd3, '0);
    for (int i = 8; i < 16; i++) begin
      do_dbg(1'b0, 1'b1, 4'(i), '0);
      chk("R8 dbg read hold", dbg_rdata, model[3]);
    end

    // R7: rejected kinds on every index
    for (int k = 2; k < 8; k++) begin
      for (int i = 0; i < 8; i++) begin
        do_cmd(3'(k), 4'(i), 32'hFFFF_FFFF);
        chk("R7 cant code", {29'd0, rsp_valid, rsp_code}, 32'd6);
        chk("R7 rdata zero", rsp_rdata, 32'd0);
        chk("R7 no notify", {31'd0, cfg_notify}, 32'd0);
      end
    end
    read_all("R7");

    // R9: simultaneous writes
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 3'd0; cmd_instr = instr_of(4'd5); cmd_wdata = 32'h1111_2222;
    dbg_wr = 1'b1; dbg_idx = 4'd5; dbg_wdata = 32'h3333_4444;
    @(negedge clk);
    cmd_valid = 1'b0; dbg_wr = 1'b0;
    model[5] = 32'h1111_2222;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_instr = instr_of(4'd6); cmd_wdata = 32'h5555_6666;
    dbg_wr = 1'b1; dbg_idx = 4'd1; dbg_wdata = 32'h0000_00A0;
    @(negedge clk);
    cmd_valid = 1'b0; dbg_wr = 1'b0;
    model[6] = 32'h5555_6666; model[1] = 32'h0000_00A0;
    chk("R9 R4 notify via dbg", {31'd0, cfg_notify}, 32'd1);
    chk("R9 cfg_out", {28'd0, cfg_out}, 32'hA);
    read_all("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule